// File: doc/BRIEF.md
# Streaming MTIE Window Evaluator

The block watches a stream of signed time-error samples, one per strobe, and reports the maximum time interval error for one window length. Consider every run of `n` back-to-back samples. For each run it takes the largest value minus the smallest value. It holds the biggest such spread seen since the last clear and presents it as the MTIE figure for an observation interval of `n` sample periods.

Two index-and-value queues track the window. One keeps its values falling and one keeps them rising, so the front of each queue is the current window's extreme. Each sample updates both queues in one cycle. The block can therefore take a strobe every clock with no stall. Software picks the window length by driving it while pulsing clear. Clear empties both queues, zeroes the held figure and drops the valid flag.

Top module: `mtie_eval`

## Requirements
- R1: After reset, and in the cycle after any clear, `mtie_o` is 0 and `mtie_vld_o` is 0.
- R2: The window length is captured from `win_len_i` only in a cycle with `clear_i` high. At any other time `win_len_i` has no effect. A captured value of 0 acts as 1, and a value above `MAX_N` acts as `MAX_N`.
- R3: `mtie_vld_o` stays low until `n` samples have been taken since the last clear. It rises two clock edges after the edge that takes the n-th sample, and it stays high until the next clear. While it is low, `mtie_o` is 0.
- R4: Once valid, `mtie_o` equals the largest value of (maximum minus minimum) over every run of `n` consecutive samples taken since the clear. Samples are 24-bit two's complement.
- R5: Between clears, `mtie_o` never decreases from one cycle to the next.
- R6: `mtie_o` is a 25-bit unsigned value. A pair of samples at -8388608 and +8388607 gives 16777215 with no wrap.
- R7: A ramp with a constant step `s` gives `(n-1)*|s|`, so the figure grows linearly with `n`.
- R8: For the same sample sequence, a longer window never gives a smaller figure than a shorter one.
- R9: A window length of 1 always gives 0.
- R10: If `clear_i` and `sample_vld_i` are high in the same cycle, the clear wins and that sample is discarded.
- R11: Cycles without a sample strobe do not change the result. The outputs stay stable once two edges have passed since the last strobe.

Ports are listed below. W denotes `SMP_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear; also captures the window length |
| sample_vld_i | input | 1 | Sample strobe |
| sample_i | input | W | Signed time-error sample |
| win_len_i | input | clog2(MAX_N+1) | Window length in samples |
| mtie_o | output | W+1 | Largest windowed peak-to-peak excursion |
| mtie_vld_o | output | 1 | MTIE figure is valid |

## Verification
The bench feeds ramps of both slopes and pseudo-random data over several window lengths. Each result is compared against a brute-force scan of every window.

Queue expiry is the first target. A design that retires an old index one sample late would widen the window, and the ramp results would come out one step too high.

Full-scale samples of opposite sign are aimed at the subtraction. A 24-bit difference would wrap there and report a small number.

Other cases probe the edges of the protocol:
- A sample strobed together with clear must not survive into the new window.
- A window length changed without clear must not take effect.
- Lengths of 0 and above the limit must clamp.
- The valid flag must not appear one sample early.

// File: rtl/mtie_pkg.sv
package mtie_pkg;
  typedef enum logic {TRACK_MAX = 1'b0, TRACK_MIN = 1'b1} trk_e;
endpackage

// File: rtl/mtie_deque.sv
module mtie_deque
  import mtie_pkg::*;
#(
  parameter int   SMP_W = 24,
  parameter int   DEPTH = 256,
  parameter int   IDX_W = 9,
  parameter trk_e POL   = TRACK_MAX
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    push_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [IDX_W-1:0]        expire_idx_i,
  output logic signed [SMP_W-1:0] front_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic signed [SMP_W-1:0] val_q [DEPTH];
  logic [IDX_W-1:0]        idx_q [DEPTH];
  logic signed [SMP_W-1:0] val_d [DEPTH];
  logic [IDX_W-1:0]        idx_d [DEPTH];
  logic [CNT_W-1:0]        cnt_q;
  logic [CNT_W-1:0]        keep;
  logic [CNT_W-1:0]        pos;
  logic [DEPTH-1:0]        beats;
  logic                    drop;

  // entries that still dominate the new sample form a prefix
  for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
    if (POL == TRACK_MAX) begin : g_max
      assign beats[j] = (CNT_W'(j) < cnt_q) && (val_q[j] > smp_i);
    end else begin : g_min
      assign beats[j] = (CNT_W'(j) < cnt_q) && (val_q[j] < smp_i);
    end
  end

  always_comb begin
    keep = '0;
    for (int j = 0; j < DEPTH; j++) keep = keep + CNT_W'(beats[j]);
  end

  // front leaves the window when its index is exactly n samples old
  assign drop = (keep != '0) && (idx_q[0] == expire_idx_i);
  assign pos  = drop ? keep - CNT_W'(1) : keep;

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    logic signed [SMP_W-1:0] nxt_v;
    logic [IDX_W-1:0]        nxt_i;
    if (j < DEPTH - 1) begin : g_sh
      assign nxt_v = val_q[j+1];
      assign nxt_i = idx_q[j+1];
    end else begin : g_end
      assign nxt_v = val_q[j];
      assign nxt_i = idx_q[j];
    end

    always_comb begin
      if (CNT_W'(j) == pos) begin
        val_d[j] = smp_i;
        idx_d[j] = idx_i;
      end else if (drop) begin
        val_d[j] = nxt_v;
        idx_d[j] = nxt_i;
      end else begin
        val_d[j] = val_q[j];
        idx_d[j] = idx_q[j];
      end
    end

    always_ff @(posedge clk_i) begin
      if (push_i && !flush_i) begin
        val_q[j] <= val_d[j];
        idx_q[j] <= idx_d[j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (flush_i) cnt_q <= '0;
    else if (push_i)  cnt_q <= pos + CNT_W'(1);
  end

  assign front_o = val_q[0];
endmodule

// File: rtl/mtie_win_ctrl.sv
module mtie_win_ctrl #(
  parameter int MAX_N = 256,
  parameter int LEN_W = 9,
  parameter int IDX_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             sample_vld_i,
  input  logic [LEN_W-1:0] win_len_i,
  output logic             push_o,
  output logic             flush_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] expire_idx_o,
  output logic             win_full_o
);
  logic [LEN_W-1:0] win_q, fill_q;
  logic [IDX_W-1:0] t_q;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    if (l == '0)                  return LEN_W'(1);
    else if (l > LEN_W'(MAX_N))   return LEN_W'(MAX_N);
    else                          return l;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= LEN_W'(1);
      fill_q <= '0;
      t_q    <= '0;
    end else if (clear_i) begin
      win_q  <= clamp_len(win_len_i);
      fill_q <= '0;
      t_q    <= '0;
    end else if (sample_vld_i) begin
      t_q <= t_q + IDX_W'(1);
      if (fill_q < win_q) fill_q <= fill_q + LEN_W'(1);
    end
  end

  assign push_o       = sample_vld_i && !clear_i;
  assign flush_o      = clear_i;
  assign idx_o        = t_q;
  assign expire_idx_o = t_q - IDX_W'(win_q);
  assign win_full_o   = push_o && (fill_q >= win_q - LEN_W'(1));
endmodule

// File: rtl/mtie_peak_hold.sv
module mtie_peak_hold #(
  parameter int SMP_W = 24,
  parameter int EXC_W = 25
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    win_full_i,
  input  logic signed [SMP_W-1:0] max_i,
  input  logic signed [SMP_W-1:0] min_i,
  output logic [EXC_W-1:0]        mtie_o,
  output logic                    mtie_vld_o
);
  logic                    go_q;
  logic signed [EXC_W-1:0] diff;
  logic [EXC_W-1:0]        exc;

  // one extra bit keeps full-scale spreads from wrapping
  assign diff = EXC_W'(max_i) - EXC_W'(min_i);
  assign exc  = diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q       <= 1'b0;
      mtie_o     <= '0;
      mtie_vld_o <= 1'b0;
    end else if (clear_i) begin
      go_q       <= 1'b0;
      mtie_o     <= '0;
      mtie_vld_o <= 1'b0;
    end else begin
      go_q <= win_full_i;
      if (go_q) begin
        mtie_vld_o <= 1'b1;
        if (exc > mtie_o) mtie_o <= exc;
      end
    end
  end
endmodule

// File: rtl/mtie_eval.sv
module mtie_eval
  import mtie_pkg::*;
#(
  parameter int SMP_W = 24,
  parameter int MAX_N = 256,
  localparam int LEN_W = $clog2(MAX_N + 1),
  localparam int EXC_W = SMP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             sample_vld_i,
  input  logic [SMP_W-1:0] sample_i,
  input  logic [LEN_W-1:0] win_len_i,
  output logic [EXC_W-1:0] mtie_o,
  output logic             mtie_vld_o
);
  localparam int IDX_W = $clog2(MAX_N) + 1;

  logic                    push, flush, win_full;
  logic [IDX_W-1:0]        idx, expire_idx;
  logic signed [SMP_W-1:0] front [2];

  mtie_win_ctrl #(.MAX_N(MAX_N), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .sample_vld_i (sample_vld_i),
    .win_len_i    (win_len_i),
    .push_o       (push),
    .flush_o      (flush),
    .idx_o        (idx),
    .expire_idx_o (expire_idx),
    .win_full_o   (win_full)
  );

  for (genvar g = 0; g < 2; g++) begin : g_dq
    mtie_deque #(
      .SMP_W(SMP_W), .DEPTH(MAX_N), .IDX_W(IDX_W),
      .POL  (g == 0 ? TRACK_MAX : TRACK_MIN)
    ) u_dq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .flush_i      (flush),
      .push_i       (push),
      .smp_i        ($signed(sample_i)),
      .idx_i        (idx),
      .expire_idx_i (expire_idx),
      .front_o      (front[g])
    );
  end

  mtie_peak_hold #(.SMP_W(SMP_W), .EXC_W(EXC_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .win_full_i (win_full),
    .max_i      (front[0]),
    .min_i      (front[1]),
    .mtie_o     (mtie_o),
    .mtie_vld_o (mtie_vld_o)
  );
endmodule

// File: rtl/mtie_eval_chk.sv
module mtie_eval_chk #(
  parameter int SMP_W = 24,
  localparam int EXC_W = SMP_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             sample_vld_i,
  input logic [EXC_W-1:0] mtie_o,
  input logic             mtie_vld_o
);
  a_r1_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (mtie_o == '0) && !mtie_vld_o);

  a_r3_zero_before_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mtie_vld_o |-> (mtie_o == '0));

  a_r3_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mtie_vld_o && !clear_i) |=> mtie_vld_o);

  a_r3_valid_after_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mtie_vld_o) |-> $past(sample_vld_i, 2));

  a_r5_no_decrease: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clear_i) |-> (mtie_o >= $past(mtie_o)));

  a_r11_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !sample_vld_i && !$past(sample_vld_i)) |=>
      ($stable(mtie_o) && $stable(mtie_vld_o)));

  // R6: spread of two 24-bit values never needs the top code range
  always_comb begin
    if (rst_ni) a_r6_range: assert (mtie_o <= EXC_W'((1 << SMP_W) - 1));
  end
endmodule

bind mtie_eval mtie_eval_chk #(.SMP_W(SMP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_i),
  .sample_vld_i (sample_vld_i),
  .mtie_o       (mtie_o),
  .mtie_vld_o   (mtie_vld_o)
);

// File: tb/mtie_eval_test.sv
module mtie_eval_test;
  localparam int SMP_W = 24;
  localparam int MAX_N = 256;
  localparam int LEN_W = $clog2(MAX_N + 1);
  localparam int EXC_W = SMP_W + 1;

  // rows: window, step, count, start, expected
  localparam int VEC [6][5] = '{
    '{4,      3, 20,   -10,    9},
    '{8,     -5, 30,   100,   35},
    '{1,      7, 10,     0,    0},
    '{16,     2, 40, -1000,   30},
    '{32,     1, 64,     5,   31},
    '{2,  -1000, 12,  4000, 1000}
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             clear_i = 1'b0;
  logic             sample_vld_i = 1'b0;
  logic [SMP_W-1:0] sample_i = '0;
  logic [LEN_W-1:0] win_len_i = LEN_W'(1);
  logic [EXC_W-1:0] mtie_o;
  logic             mtie_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int hist [1024];
  int hlen = 0;
  int rnd [100];

  always #2 clk = ~clk;

  mtie_eval #(.SMP_W(SMP_W), .MAX_N(MAX_N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i),
    .sample_vld_i(sample_vld_i), .sample_i(sample_i), .win_len_i(win_len_i),
    .mtie_o(mtie_o), .mtie_vld_o(mtie_vld_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr(input int len);
    @(negedge clk);
    clear_i   = 1'b1;
    win_len_i = LEN_W'(len);
    @(negedge clk);
    clear_i = 1'b0;
    hlen    = 0;
  endtask

  task automatic push(input int v);
    @(negedge clk);
    sample_vld_i = 1'b1;
    sample_i     = v[SMP_W-1:0];
    hist[hlen]   = v;
    hlen++;
  endtask

  task automatic settle();
    @(negedge clk);
    sample_vld_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int model(input int n_in);
    int n, best, mx, mn;
    n = (n_in == 0) ? 1 : (n_in > MAX_N ? MAX_N : n_in);
    best = 0;
    for (int i = 0; i + n <= hlen; i++) begin
      mx = hist[i];
      mn = hist[i];
      for (int k = i; k < i + n; k++) begin
        if (hist[k] > mx) mx = hist[k];
        if (hist[k] < mn) mn = hist[k];
      end
      if (mx - mn > best) best = mx - mn;
    end
    return best;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    int prev, cur;
    s = 32'h1234_5677;
    for (int i = 0; i < 100; i++) begin
      logic [SMP_W-1:0] b;
      s = s * 32'd1103515245 + 32'd12345;
      b = s[30:7];
      rnd[i] = int'($signed(b));
    end

    repeat (3) @(negedge clk);
    check("R1 reset mtie", mtie_o, 0);
    check("R1 reset valid", mtie_vld_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // ramp table
    for (int r = 0; r < 6; r++) begin
      clr(VEC[r][0]);
      for (int k = 0; k < VEC[r][2]; k++) push(VEC[r][3] + k * VEC[r][1]);
      settle();
      check(VEC[r][0] == 1 ? "R9 single-sample window" : "R7 ramp", mtie_o, VEC[r][4]);
      check("R3 valid after ramp", mtie_vld_o, 1);
    end

    // R3 valid timing
    clr(5);
    check("R1 after clear", mtie_vld_o, 0);
    for (int k = 0; k < 4; k++) push(k * 10);
    settle();
    check("R3 not valid at n-1", mtie_vld_o, 0);
    check("R3 zero before valid", mtie_o, 0);
    push(40);
    settle();
    check("R3 valid at n", mtie_vld_o, 1);
    check("R4 first window", mtie_o, 40);

    // R4 / R8 pseudo-random data over several windows
    prev = 0;
    for (int w = 0; w < 4; w++) begin
      int n;
      n = (w == 0) ? 1 : (w == 1) ? 3 : (w == 2) ? 10 : 50;
      clr(n);
      for (int k = 0; k < 100; k++) push(rnd[k]);
      settle();
      cur = int'(mtie_o);
      check("R4 random window", cur, model(n));
      if (n == 1) check("R9 random n=1", cur, 0);
      check("R8 monotone in n", (cur >= prev) ? 1 : 0, 1);
      prev = cur;
    end

    // R6 full scale
    clr(2);
    push(-8388608);
    push(8388607);
    settle();
    check("R6 full-scale spread", mtie_o, 16777215);

    // R2 length ignored without clear
    clr(3);
    push(0);
    push(1);
    win_len_i = LEN_W'(10);
    for (int k = 2; k < 12; k++) push(k);
    settle();
    check("R2 length held", mtie_o, 2);

    // R2 clamp low
    clr(0);
    push(7);
    settle();
    check("R2 zero acts as one valid", mtie_vld_o, 1);
    push(50);
    settle();
    check("R2 zero acts as one", mtie_o, 0);

    // R2 clamp high, with R3 boundary
    clr(300);
    for (int k = 0; k < 255; k++) push(k);
    settle();
    check("R3 clamp not valid at 255", mtie_vld_o, 0);
    for (int k = 255; k < 260; k++) push(k);
    settle();
    check("R2 clamp high valid", mtie_vld_o, 1);
    check("R2 clamp high value", mtie_o, 255);

    // R10 clear wins over sample
    clr(2);
    push(0);
    push(100);
    settle();
    check("R10 pre value", mtie_o, 100);
    @(negedge clk);
    clear_i = 1'b1; sample_vld_i = 1'b1; sample_i = SMP_W'(5000); win_len_i = LEN_W'(2);
    @(negedge clk);
    clear_i = 1'b0; sample_vld_i = 1'b0; hlen = 0;
    repeat (2) @(negedge clk);
    check("R10 cleared value", mtie_o, 0);
    check("R10 cleared valid", mtie_vld_o, 0);
    push(0);
    push(10);
    settle();
    check("R10 colliding sample dropped", mtie_o, 10);

    // R11 gaps between samples
    clr(4);
    for (int k = 0; k < 12; k++) begin
      push(rnd[k] / 256);
      settle();
    end
    check("R11 gapped stream", mtie_o, model(4));
    cur = int'(mtie_o);
    repeat (20) @(negedge clk);
    check("R11 idle value", mtie_o, cur);
    check("R11 idle valid", mtie_vld_o, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule